// File: doc/BRIEF.md
# Dual 16-bit signed multiply-accumulate

This block is the packed-halfword multiply stage of an integer core. One 32-bit operand word `opn_n` and one 32-bit operand word `opn_m` are split into signed 16-bit halves. The block forms two signed products, one from the lower halves and one from the upper halves. It then either adds the two products or subtracts the upper product from the lower one. An accumulator word can be added to that result as an option. Before the multiply, the halves of `opn_m` can be exchanged, so the lower half of n meets the upper half of m.

The block decodes the operation from the instruction word it receives. The source register indices are output at once, so the register file can supply the operands in the same cycle. The destination index travels with the result, which is registered one cycle later. When the condition field is not "always", the surrounding core reports through `cond_pass` whether the condition holds; a failed condition writes nothing. Results wrap modulo 2^32 and are never clamped. Instead, any signed overflow in one of the additions sets a sticky flag, which only the synchronous clear or reset can lower.

Top module: `dmac_dual16`

## Requirements
- R1: Index outputs are combinational from `instr`: `n_sel` = bits 3:0, `m_sel` = bits 11:8, `acc_sel` = bits 15:12. The destination index (bits 19:16) appears on `out_dest` with the result.
- R2: When instruction bit 5 is 1, the two 16-bit halves of `opn_m` are exchanged before the multiply. When the bit is 0, `opn_m` is used as it is.
- R3: Two signed 16x16 products are formed: low half of n times low half of the (possibly exchanged) m, and high half of n times high half of m.
- R4: Instruction bit 6 selects how the products combine: 0 gives low product + high product, 1 gives low product - high product.
- R5: An accumulator index of 15 means no accumulation. Any other index adds `opn_acc` to the combined products.
- R6: The overflow flag is set by a signed overflow of the product addition (add mode only) or of the accumulator addition. A subtract of the products never sets it.
- R7: `q_flag` is 0 after reset and stays set once set. A `q_clr` pulse clears it on the next edge, and the clear wins over a set in the same cycle.
- R8: Condition field bits 31:28 equal to 0xE always execute. Any other value executes only when `cond_pass` is 1. A failed operation gives no `out_valid`, keeps `out_data` unchanged and leaves `q_flag` unchanged.
- R9: Results appear one cycle after the accepted input, with `out_valid` high for that one cycle. `out_data` holds its last value while `out_valid` is low.
- R10: All sums wrap modulo 2^32, and `out_data` is the low 32 bits of the result with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered this cycle |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | External condition result |
| opn_n | input | 32 | First packed operand |
| opn_m | input | 32 | Second packed operand |
| opn_acc | input | 32 | Accumulator operand |
| q_clr | input | 1 | Synchronous clear of the overflow flag |
| n_sel | output | 4 | Index of the n operand |
| m_sel | output | 4 | Index of the m operand |
| acc_sel | output | 4 | Index of the accumulator operand |
| out_valid | output | 1 | Result strobe |
| out_data | output | 32 | Result word |
| out_dest | output | 4 | Destination index of the result |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong product lane or a wrong combine selection shows up on `out_data` in the cycle right after the operation. The bench sweeps every combination of eight edge-value halfwords in all four operand halves, so that error cannot hide. A flag update that is wrong stays visible: once `q_flag` is set, it stays set, so a false set is seen at the next check and on every check after it until the next clear. A false miss is seen on the first overflowing operation. A condition gate that is broken shows up as a stray `out_valid` pulse, or as a changed `out_data` or flag, in the cycle after a failed operation.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int IDXW      = 4;
    localparam int CONDW     = 4;
    // instruction field positions (low bit of each field)
    localparam int POS_N     = 0;
    localparam int POS_M     = 8;
    localparam int POS_ACC   = 12;
    localparam int POS_DEST  = 16;
    localparam int POS_COND  = 28;
    localparam int POS_SWAP  = 5;
    localparam int POS_SUB   = 6;
    localparam logic [CONDW-1:0] COND_ALWAYS = 4'hE;
    localparam logic [IDXW-1:0]  IDX_NOACC   = 4'hF;

    typedef struct packed {
        logic [CONDW-1:0] cond;
        logic [IDXW-1:0]  n_idx;
        logic [IDXW-1:0]  m_idx;
        logic [IDXW-1:0]  a_idx;
        logic [IDXW-1:0]  d_idx;
        logic             swap;
        logic             sub;
    } dmac_dec_t;
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
    import dmac_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic [IW-1:0] instr,
    output dmac_dec_t     dec
);
    logic unused_bits;

    always_comb begin
        dec.cond  = instr[POS_COND +: CONDW];
        dec.n_idx = instr[POS_N    +: IDXW];
        dec.m_idx = instr[POS_M    +: IDXW];
        dec.a_idx = instr[POS_ACC  +: IDXW];
        dec.d_idx = instr[POS_DEST +: IDXW];
        dec.swap  = instr[POS_SWAP];
        dec.sub   = instr[POS_SUB];
    end

    // opcode bits not used for this operation class
    assign unused_bits = ^{instr[27:20], instr[7], instr[4]};
endmodule

// File: rtl/dmac_halfmul.sv
module dmac_halfmul #(
    parameter int HW = 16
) (
    input  logic [HW-1:0]   a,
    input  logic [HW-1:0]   b,
    output logic [2*HW-1:0] prod
);
    logic signed [2*HW-1:0] a_ext;
    logic signed [2*HW-1:0] b_ext;

    always_comb begin
        a_ext = {{HW{a[HW-1]}}, a};
        b_ext = {{HW{b[HW-1]}}, b};
        prod  = a_ext * b_ext;
    end
endmodule

// File: rtl/dmac_combine.sv
module dmac_combine #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] p_lo,
    input  logic [DW-1:0] p_hi,
    input  logic          sub,
    input  logic          acc_en,
    input  logic [DW-1:0] acc,
    output logic [DW-1:0] result,
    output logic          ovf
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] pair;
    logic [DW-1:0] total;
    logic          pair_ovf;
    logic          acc_ovf;
    logic          diff_ovf;

    always_comb begin
        pair     = sub ? (p_lo - p_hi) : (p_lo + p_hi);
        pair_ovf = !sub && (p_lo[MSB] == p_hi[MSB]) && (pair[MSB] != p_lo[MSB]);
        diff_ovf = sub && (p_lo[MSB] != p_hi[MSB]) && (pair[MSB] != p_lo[MSB]);
        total    = pair + acc;
        acc_ovf  = acc_en && (pair[MSB] == acc[MSB]) && (total[MSB] != pair[MSB]);
        result   = acc_en ? total : pair;
        ovf      = pair_ovf || acc_ovf;
    end

    // R6: products of signed halves can never make the difference overflow
    always_comb begin
        p_sub_pair_safe_r6: assert (!diff_ovf || $isunknown({p_lo, p_hi, sub}));
    end
endmodule

// File: rtl/dmac_dual16.sv
module dmac_dual16
    import dmac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic            cond_pass,
    input  logic [DW-1:0]   opn_n,
    input  logic [DW-1:0]   opn_m,
    input  logic [DW-1:0]   opn_acc,
    input  logic            q_clr,
    output logic [IDXW-1:0] n_sel,
    output logic [IDXW-1:0] m_sel,
    output logic [IDXW-1:0] acc_sel,
    output logic            out_valid,
    output logic [DW-1:0]   out_data,
    output logic [IDXW-1:0] out_dest,
    output logic            q_flag
);
    localparam int HW     = DW / 2;
    localparam int NLANES = 2;

    typedef struct packed {
        logic            valid;
        logic [DW-1:0]   data;
        logic [IDXW-1:0] dest;
        logic            q;
    } dmac_state_t;

    dmac_dec_t     dec;
    dmac_state_t   st_d, st_q;
    logic [DW-1:0] m_eff;
    logic [DW-1:0] prods [NLANES];
    logic [DW-1:0] comb_res;
    logic          comb_ovf;
    logic          acc_en;
    logic          fire;

    dmac_decode #(.IW(32)) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign m_eff  = dec.swap ? {opn_m[HW-1:0], opn_m[DW-1:HW]} : opn_m;
    assign acc_en = (dec.a_idx != IDX_NOACC);
    assign fire   = in_valid && ((dec.cond == COND_ALWAYS) || cond_pass);

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        dmac_halfmul #(.HW(HW)) u_mul (
            .a    (opn_n[g*HW +: HW]),
            .b    (m_eff[g*HW +: HW]),
            .prod (prods[g])
        );
    end

    dmac_combine #(.DW(DW)) u_comb (
        .p_lo   (prods[0]),
        .p_hi   (prods[1]),
        .sub    (dec.sub),
        .acc_en (acc_en),
        .acc    (opn_acc),
        .result (comb_res),
        .ovf    (comb_ovf)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = fire;
        if (fire) begin
            st_d.data = comb_res;
            st_d.dest = dec.d_idx;
        end
        if (q_clr)
            st_d.q = 1'b0;
        else if (fire && comb_ovf)
            st_d.q = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign n_sel     = dec.n_idx;
    assign m_sel     = dec.m_idx;
    assign acc_sel   = dec.a_idx;
    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_dest  = st_q.dest;
    assign q_flag    = st_q.q;

    p_valid_needs_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    p_failed_cond_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !cond_pass && (instr[31:28] != COND_ALWAYS)) |-> !out_valid);
    p_data_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));
    p_q_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q_clr) |-> !q_flag);
    p_q_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q_flag) && !$past(q_clr)) |-> q_flag);
    p_q_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!fire) && !$past(q_clr)) |-> (q_flag == $past(q_flag)));
endmodule

// File: tb/tb_dmac_dual16.sv
module tb_dmac_dual16;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic [31:0] instr = '0;
    logic        cond_pass = 0;
    logic [31:0] opn_n = '0, opn_m = '0, opn_acc = '0;
    logic        q_clr = 0;
    logic [3:0]  n_sel, m_sel, acc_sel, out_dest;
    logic        out_valid, q_flag;
    logic [31:0] out_data;

    int errors = 0;
    int checks = 0;
    logic        q_exp = 0;
    logic [31:0] data_exp = '0;
    logic [3:0]  dest_exp = '0;
    bit          done = 0;

    always #2 clk = ~clk;

    dmac_dual16 dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .cond_pass(cond_pass), .opn_n(opn_n), .opn_m(opn_m), .opn_acc(opn_acc),
        .q_clr(q_clr), .n_sel(n_sel), .m_sel(m_sel), .acc_sel(acc_sel),
        .out_valid(out_valid), .out_data(out_data), .out_dest(out_dest),
        .q_flag(q_flag)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_instr(input logic [3:0] cond, input logic [3:0] d,
        input logic [3:0] a, input logic [3:0] m, input logic [3:0] n,
        input bit sw, input bit sub);
        return {cond, 8'h70, d, a, m, 1'b0, sub, sw, 1'b1, n};
    endfunction

    // arithmetic reference built from exact integers
    task automatic model(input logic [31:0] n, input logic [31:0] m, input logic [31:0] acc,
                         input bit sw, input bit sub, input bit use_acc,
                         output logic [31:0] r, output bit ovf);
        logic [31:0] mm;
        longint lo, hi, pair, tot;
        logic [31:0] pair32;
        mm = sw ? {m[15:0], m[31:16]} : m;
        lo = longint'($signed(n[15:0])) * longint'($signed(mm[15:0]));
        hi = longint'($signed(n[31:16])) * longint'($signed(mm[31:16]));
        pair = sub ? lo - hi : lo + hi;
        ovf = (pair > 64'sd2147483647) || (pair < -64'sd2147483648);
        pair32 = pair[31:0];
        r = pair32;
        if (use_acc) begin
            tot = longint'($signed(pair32)) + longint'($signed(acc));
            if ((tot > 64'sd2147483647) || (tot < -64'sd2147483648)) ovf = 1;
            r = tot[31:0];
        end
    endtask

    task automatic run_op(input logic [31:0] ins, input logic [31:0] n, input logic [31:0] m,
                          input logic [31:0] acc, input bit cp, input bit clr, input string tag);
        logic [31:0] r;
        bit ovf, fire;
        @(negedge clk);
        in_valid = 1; instr = ins; opn_n = n; opn_m = m; opn_acc = acc;
        cond_pass = cp; q_clr = clr;
        model(n, m, acc, ins[5], ins[6], ins[15:12] != 4'hF, r, ovf);
        fire = (ins[31:28] == 4'hE) || cp;
        if (clr) q_exp = 0;
        else if (fire && ovf) q_exp = 1;
        if (fire) begin data_exp = r; dest_exp = ins[19:16]; end
        @(posedge clk);
        #1;
        check(out_valid == fire && out_data == data_exp && out_dest == dest_exp, tag,
              {27'd0, out_valid, out_dest, out_data}, {27'd0, fire, dest_exp, data_exp});
        check(q_flag == q_exp, tag, {63'd0, q_flag}, {63'd0, q_exp});
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] vals [8];
        logic [31:0] accs [4];
        vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234, 16'hC001, 16'h00FF};
        accs = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'h12345678};

        repeat (3) @(posedge clk);
        #1;
        // R7 R9 reset state
        check(!out_valid && !q_flag && out_data == 0, "R7", {31'd0, out_valid, q_flag, out_data}, 64'd0);
        @(negedge clk);
        rst_n = 1;

        // R1 index decode
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            instr = mk_instr(4'hE, 4'(k), 4'(15 - k), 4'(k ^ 5), 4'(k ^ 10), 0, 0);
            #1;
            check(n_sel == 4'(k ^ 10) && m_sel == 4'(k ^ 5) && acc_sel == 4'(15 - k), "R1",
                  {52'd0, n_sel, m_sel, acc_sel}, {52'd0, 4'(k ^ 10), 4'(k ^ 5), 4'(15 - k)});
        end

        // R3 signed lanes, R2 swap
        run_op(mk_instr(4'hE, 4'd3, 4'hF, 4'd1, 4'd2, 0, 0), 32'h8000_0002, 32'h8000_FFFD, 0, 0, 0, "R3");
        run_op(mk_instr(4'hE, 4'd4, 4'hF, 4'd1, 4'd2, 1, 0), 32'h0003_0005, 32'h0007_000B, 0, 0, 0, "R2");
        // R4 subtract
        run_op(mk_instr(4'hE, 4'd5, 4'hF, 4'd1, 4'd2, 0, 1), 32'h0003_0005, 32'h0007_000B, 0, 0, 0, "R4");
        // R6 sub never flags
        run_op(mk_instr(4'hE, 4'd5, 4'hF, 4'd1, 4'd2, 0, 1), 32'h8000_8000, 32'h8000_8000, 0, 0, 0, "R6");
        // R6 pair overflow in add mode, R10 wrap
        run_op(mk_instr(4'hE, 4'd6, 4'hF, 4'd1, 4'd2, 0, 0), 32'h8000_8000, 32'h8000_8000, 0, 0, 0, "R6");
        // R8 failed condition: no write, flag unchanged
        run_op(mk_instr(4'h3, 4'd7, 4'd0, 4'd1, 4'd2, 0, 0), 32'h0001_0001, 32'h0001_0001, 5, 0, 0, "R8");
        // R7 clear
        run_op(mk_instr(4'h3, 4'd7, 4'd0, 4'd1, 4'd2, 0, 0), 0, 0, 0, 0, 1, "R7");
        // R5 R10 accumulator wrap with overflow
        run_op(mk_instr(4'hE, 4'd8, 4'd9, 4'd1, 4'd2, 0, 0), 32'h0000_0001, 32'h0000_0001, 32'h7FFFFFFF, 0, 0, "R10");
        // R7 clear beats set in same cycle
        run_op(mk_instr(4'hE, 4'd8, 4'd9, 4'd1, 4'd2, 0, 0), 32'h0000_0001, 32'h0000_0001, 32'h7FFFFFFF, 0, 1, "R7");
        // R8 condition passes externally
        run_op(mk_instr(4'h0, 4'd2, 4'd9, 4'd1, 4'd2, 0, 0), 32'h0002_0002, 32'h0003_0003, 1, 1, 0, "R8");

        // near-exhaustive sweep
        for (int i = 0; i < 4096; i++) begin
            logic [31:0] n, m, acc;
            logic [3:0] ai, cond;
            bit sw, sub, cp, clr;
            string tag;
            n   = {vals[i[5:3]], vals[i[2:0]]};
            m   = {vals[i[11:9]], vals[i[8:6]]};
            sw  = i[0] ^ i[4];
            sub = i[1] ^ i[7];
            ai  = (i % 3 == 0) ? 4'hF : 4'(i % 15);
            acc = accs[i[10:9] ^ i[1:0]];
            cond = (i % 11 == 0) ? 4'h1 : 4'hE;
            cp  = i[4];
            clr = (i % 97 == 0);
            if (cond != 4'hE && !cp) tag = "R8";
            else if (clr) tag = "R7";
            else if (ai == 4'hF) tag = sub ? "R4" : "R3";
            else tag = sw ? "R2" : "R5";
            run_op(mk_instr(cond, 4'(i), ai, 4'd1, 4'd2, sw, sub), n, m, acc, cp, clr, tag);
        end

        // R9 idle: no valid, data held
        @(negedge clk);
        in_valid = 0; q_clr = 0;
        @(posedge clk);
        #1;
        check(!out_valid && out_data == data_exp, "R9", {31'd0, out_valid, out_data}, {32'd0, data_exp});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule